// File: doc/BRIEF.md
# DMA Address Decode Window Unit

This block sits between a DMA engine and the system interconnect. It maps each DMA bus address onto one of six programmable address windows. Every window has three registers: a base register, a size register and a high-address remap register. Two further registers are shared by all windows. One holds an active-low enable bit per window. The other holds a packed 2-bit access permission per window. For each lookup the block reports one of three outcomes: the matching window with its routing data (target ID, attribute and remap word), a miss, or a permission violation.

A lookup enters on `lk_valid` together with `lk_addr` and `lk_write`. The outcome appears on the `res_*` outputs one clock later. The outcome is held in a small result state machine with four states:

- S_IDLE: no result this cycle.
- S_GRANT: a window matched and the access is allowed.
- S_MISS: no enabled window matched.
- S_DENY: a window matched but its permission refuses the access.

Each cycle the machine moves to one of these states. It goes to S_IDLE when `lk_valid` is low. When `lk_valid` is high it goes to S_MISS, S_GRANT or S_DENY, according to the lookup. Software programs the windows through a write-only configuration port.

Top module: `dma_win_decode`

## Requirements
- R1: After reset every window is disabled (enable register all ones) and every permission is 00, so any lookup reports a miss, and `res_valid` is low until a lookup is made.
- R2: Enable bit w (bit w of the enable register) set to 0 enables window w. Writing 0x3F disables all six windows, so every lookup then misses.
- R3: Window w matches when bits [31:16] of the address equal bits [31:16] of its base register, comparing only the bit positions where the size field (size register bits [31:16], holding window bytes / 64 KiB − 1) is 0.
- R4: When several enabled windows match, the lowest-numbered one is reported.
- R5: On a match, `res_win` gives the window number. `res_target` is base register bits [3:0], `res_attr` is base bits [15:8] and `res_remap` is the window's remap register. `res_perm` is the window's permission field.
- R6: Window w's permission is bits [2w+1:2w] of the protection register. 11 allows reads and writes, 01 allows reads only, and 00 and 10 allow nothing. A refused access on a matching window reports `res_deny` instead of `res_grant`.
- R7: When no enabled window matches, `res_miss` is high and `res_grant`/`res_deny` are low.
- R8: A lookup presented on `lk_valid` at a clock edge produces `res_valid` with exactly one of grant/miss/deny in the next cycle. A cycle without `lk_valid` gives `res_valid` low in the next cycle. Back-to-back lookups produce back-to-back results.
- R9: `cfg_addr` = {kind[1:0], index[2:0]}. Kind 0 selects the base register of window `index`, kind 1 its size register and kind 2 its remap register. Kind 3 with index 0 selects the enable register and kind 3 with index 1 the protection register. Writes with index 6 or 7 for kinds 0–2, and kind 3 with index 2–7, change nothing.
- R10: When the result is a miss or idle, `res_win`, `res_target`, `res_attr`, `res_remap` and `res_perm` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Register select {kind, index} |
| cfg_wdata | input | 32 | Configuration write data |
| lk_valid | input | 1 | Lookup request valid |
| lk_write | input | 1 | Lookup is a write access |
| lk_addr | input | 32 | Lookup bus address |
| res_valid | output | 1 | Result present this cycle |
| res_grant | output | 1 | Matching window allows the access |
| res_miss | output | 1 | No enabled window matched |
| res_deny | output | 1 | Matching window refuses the access |
| res_win | output | 3 | Selected window number |
| res_target | output | 4 | Target ID of selected window |
| res_attr | output | 8 | Attribute of selected window |
| res_remap | output | 32 | High-address remap word of selected window |
| res_perm | output | 2 | Permission field of selected window |

## Verification
The bench places addresses on both sides of each window edge, including the last word inside a 256 KiB window and the first word past it. A size mask applied to the wrong bits, or not inverted, shows up there as a false hit or a false miss. Windows overlap on purpose, so a priority encoder that favours the highest index would report window 1 where window 0 is expected. Each permission code is exercised on reads and writes. The code 10 sits in window 5's top bit pair, where a wrong shift would read another window's field or grant a reserved code. Writes to the missing indices 6 and 7 and to unused shared slots are followed by lookups on configured windows. An index decode that wraps or ignores the top bit would then corrupt window 0 or the enable mask.

// File: rtl/dma_win_pkg.sv
package dma_win_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_GRANT = 2'd1,
        S_MISS  = 2'd2,
        S_DENY  = 2'd3
    } dec_state_e;

    typedef enum logic [1:0] {
        RK_BASE   = 2'd0,
        RK_SIZE   = 2'd1,
        RK_REMAP  = 2'd2,
        RK_SHARED = 2'd3
    } reg_kind_e;

    localparam logic [1:0] PERM_NONE = 2'b00;
    localparam logic [1:0] PERM_RO   = 2'b01;
    localparam logic [1:0] PERM_FULL = 2'b11;

    localparam int SH_ENABLE  = 0;
    localparam int SH_PROTECT = 1;

    localparam int TGT_W  = 4;
    localparam int ATTR_W = 8;
    localparam int ATTR_LSB = 8;

endpackage

// File: rtl/dma_win_regs.sv
module dma_win_regs
    import dma_win_pkg::*;
#(
    parameter int NWIN   = 6,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_kind,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [ADDR_W-1:0]   cfg_wdata,
    output logic [ADDR_W-1:0]   base_q  [NWIN],
    output logic [ADDR_W-1:0]   size_q  [NWIN],
    output logic [ADDR_W-1:0]   remap_q [NWIN],
    output logic [NWIN-1:0]     en_n_q,
    output logic [2*NWIN-1:0]   prot_q
);

    logic shared_sel;
    assign shared_sel = cfg_we && (reg_kind_e'(cfg_kind) == RK_SHARED);

    // per-window registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < NWIN; w++) begin
                base_q[w]  <= '0;
                size_q[w]  <= '0;
                remap_q[w] <= '0;
            end
        end else if (cfg_we) begin
            for (int w = 0; w < NWIN; w++) begin
                if (cfg_idx == IDX_W'(w)) begin
                    unique case (reg_kind_e'(cfg_kind))
                        RK_BASE:   base_q[w]  <= cfg_wdata;
                        RK_SIZE:   size_q[w]  <= cfg_wdata;
                        RK_REMAP:  remap_q[w] <= cfg_wdata;
                        RK_SHARED: ;
                    endcase
                end
            end
        end
    end

    // shared enable (active low) and packed permission registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_n_q <= '1;
            prot_q <= '0;
        end else if (shared_sel) begin
            if (cfg_idx == IDX_W'(SH_ENABLE))
                en_n_q <= cfg_wdata[NWIN-1:0];
            if (cfg_idx == IDX_W'(SH_PROTECT))
                prot_q <= cfg_wdata[2*NWIN-1:0];
        end
    end

endmodule

// File: rtl/dma_win_match.sv
module dma_win_match #(
    parameter int NWIN     = 6,
    parameter int ADDR_W   = 32,
    parameter int PAGE_LSB = 16
) (
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [ADDR_W-1:0] base_q [NWIN],
    input  logic [ADDR_W-1:0] size_q [NWIN],
    input  logic [NWIN-1:0]   en_n_q,
    output logic [NWIN-1:0]   hit_vec
);

    localparam int PW = ADDR_W - PAGE_LSB;

    for (genvar w = 0; w < NWIN; w++) begin : g_cmp
        logic [PW-1:0] diff;
        // size field bits set to 1 are don't-care positions
        assign diff = (lk_addr[ADDR_W-1:PAGE_LSB] ^ base_q[w][ADDR_W-1:PAGE_LSB])
                      & ~size_q[w][ADDR_W-1:PAGE_LSB];
        assign hit_vec[w] = !en_n_q[w] && (diff == '0);
    end

endmodule

// File: rtl/dma_win_prio.sv
module dma_win_prio #(
    parameter int NWIN  = 6,
    parameter int IDX_W = 3
) (
    input  logic [NWIN-1:0]  hit_vec,
    output logic             any_hit,
    output logic [IDX_W-1:0] win_idx
);

    // lowest index wins: scan downward so the last assignment is the lowest hit
    always_comb begin
        any_hit = |hit_vec;
        win_idx = '0;
        for (int w = NWIN - 1; w >= 0; w--) begin
            if (hit_vec[w])
                win_idx = IDX_W'(w);
        end
    end

endmodule

// File: rtl/dma_win_decode.sv
module dma_win_decode
    import dma_win_pkg::*;
#(
    parameter int NWIN     = 6,
    parameter int ADDR_W   = 32,
    parameter int PAGE_LSB = 16,
    localparam int IDX_W   = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int CFG_AW  = IDX_W + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [ADDR_W-1:0]   cfg_wdata,
    input  logic                lk_valid,
    input  logic                lk_write,
    input  logic [ADDR_W-1:0]   lk_addr,
    output logic                res_valid,
    output logic                res_grant,
    output logic                res_miss,
    output logic                res_deny,
    output logic [IDX_W-1:0]    res_win,
    output logic [TGT_W-1:0]    res_target,
    output logic [ATTR_W-1:0]   res_attr,
    output logic [ADDR_W-1:0]   res_remap,
    output logic [1:0]          res_perm
);

    logic [ADDR_W-1:0] base_q  [NWIN];
    logic [ADDR_W-1:0] size_q  [NWIN];
    logic [ADDR_W-1:0] remap_q [NWIN];
    logic [NWIN-1:0]   en_n_q;
    logic [2*NWIN-1:0] prot_q;
    logic [NWIN-1:0]   hit_vec;
    logic              any_hit;
    logic [IDX_W-1:0]  win_idx;

    dma_win_regs #(.NWIN(NWIN), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_kind  (cfg_addr[CFG_AW-1:IDX_W]),
        .cfg_idx   (cfg_addr[IDX_W-1:0]),
        .cfg_wdata (cfg_wdata),
        .base_q    (base_q),
        .size_q    (size_q),
        .remap_q   (remap_q),
        .en_n_q    (en_n_q),
        .prot_q    (prot_q)
    );

    dma_win_match #(.NWIN(NWIN), .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB)) match_i (
        .lk_addr (lk_addr),
        .base_q  (base_q),
        .size_q  (size_q),
        .en_n_q  (en_n_q),
        .hit_vec (hit_vec)
    );

    dma_win_prio #(.NWIN(NWIN), .IDX_W(IDX_W)) prio_i (
        .hit_vec (hit_vec),
        .any_hit (any_hit),
        .win_idx (win_idx)
    );

    dec_state_e  state_q, state_d;
    logic [1:0]  perm_sel;
    logic        allow;

    logic [IDX_W-1:0]  win_q;
    logic [TGT_W-1:0]  tgt_q;
    logic [ATTR_W-1:0] attr_q;
    logic [ADDR_W-1:0] remap_sel_q;
    logic [1:0]        perm_q;

    always_comb begin
        perm_sel = prot_q[{win_idx, 1'b0} +: 2];
        allow    = (perm_sel == PERM_FULL) || ((perm_sel == PERM_RO) && !lk_write);
        state_d  = S_IDLE;
        if (lk_valid) begin
            if (!any_hit)
                state_d = S_MISS;
            else if (allow)
                state_d = S_GRANT;
            else
                state_d = S_DENY;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // captured window data, zero unless a window matched
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q       <= '0;
            tgt_q       <= '0;
            attr_q      <= '0;
            remap_sel_q <= '0;
            perm_q      <= '0;
        end else if (lk_valid && any_hit) begin
            win_q       <= win_idx;
            tgt_q       <= base_q[win_idx][TGT_W-1:0];
            attr_q      <= base_q[win_idx][ATTR_LSB +: ATTR_W];
            remap_sel_q <= remap_q[win_idx];
            perm_q      <= perm_sel;
        end else begin
            win_q       <= '0;
            tgt_q       <= '0;
            attr_q      <= '0;
            remap_sel_q <= '0;
            perm_q      <= '0;
        end
    end

    // outputs decoded from state
    always_comb begin
        res_valid = 1'b0;
        res_grant = 1'b0;
        res_miss  = 1'b0;
        res_deny  = 1'b0;
        unique case (state_q)
            S_IDLE:  ;
            S_GRANT: begin res_valid = 1'b1; res_grant = 1'b1; end
            S_MISS:  begin res_valid = 1'b1; res_miss  = 1'b1; end
            S_DENY:  begin res_valid = 1'b1; res_deny  = 1'b1; end
        endcase
        res_win    = win_q;
        res_target = tgt_q;
        res_attr   = attr_q;
        res_remap  = remap_sel_q;
        res_perm   = perm_q;
    end

endmodule

// File: rtl/dma_win_decode_chk.sv
module dma_win_decode_chk #(
    parameter int NWIN  = 6,
    parameter int IDX_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [IDX_W+1:0]  cfg_addr,
    input logic [31:0]       cfg_wdata,
    input logic              lk_valid,
    input logic              lk_write,
    input logic              res_valid,
    input logic              res_grant,
    input logic              res_miss,
    input logic              res_deny,
    input logic [1:0]        res_perm,
    input logic [NWIN-1:0]   en_n_q
);

    // R8
    lookup_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    // R8
    idle_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    // R2
    all_disabled_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && (&en_n_q)) |=> res_miss);

    // R2
    disable_all_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == {2'b11, {IDX_W{1'b0}}} && (&cfg_wdata[NWIN-1:0]))
        |=> (&en_n_q));

    // R6
    ro_write_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_write) |=> !(res_grant && res_perm == 2'b01));

    // R6
    deny_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_deny |-> (res_perm != 2'b11));

endmodule

bind dma_win_decode dma_win_decode_chk #(.NWIN(NWIN), .IDX_W(IDX_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .lk_valid  (lk_valid),
    .lk_write  (lk_write),
    .res_valid (res_valid),
    .res_grant (res_grant),
    .res_miss  (res_miss),
    .res_deny  (res_deny),
    .res_perm  (res_perm),
    .en_n_q    (en_n_q)
);

// File: tb/dma_win_decode_tb_top.sv
`timescale 1ns/1ps
module dma_win_decode_tb_top;

    localparam int NWIN  = 6;
    localparam int IDX_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              cfg_we = 1'b0;
    logic [IDX_W+1:0]  cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic              lk_valid = 1'b0;
    logic              lk_write = 1'b0;
    logic [31:0]       lk_addr = '0;
    logic              res_valid, res_grant, res_miss, res_deny;
    logic [IDX_W-1:0]  res_win;
    logic [3:0]        res_target;
    logic [7:0]        res_attr;
    logic [31:0]       res_remap;
    logic [1:0]        res_perm;

    dma_win_decode dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .lk_valid(lk_valid), .lk_write(lk_write), .lk_addr(lk_addr),
        .res_valid(res_valid), .res_grant(res_grant), .res_miss(res_miss),
        .res_deny(res_deny), .res_win(res_win), .res_target(res_target),
        .res_attr(res_attr), .res_remap(res_remap), .res_perm(res_perm)
    );

    typedef struct packed {
        logic             grant;
        logic             miss;
        logic             deny;
        logic [IDX_W-1:0] win;
        logic [3:0]       tgt;
        logic [7:0]       attr;
        logic [31:0]      remap;
        logic [1:0]       perm;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    logic [31:0]       sh_base  [NWIN];
    logic [31:0]       sh_size  [NWIN];
    logic [31:0]       sh_remap [NWIN];
    logic [NWIN-1:0]   sh_en_n = '1;
    logic [2*NWIN-1:0] sh_prot = '0;

    function automatic exp_t model(input logic [31:0] a, input logic wr);
        exp_t e = '0;
        bit   found = 1'b0;
        int   fw = 0;
        logic [1:0] p;
        for (int w = NWIN - 1; w >= 0; w--) begin
            if (!sh_en_n[w] &&
                (((a[31:16] ^ sh_base[w][31:16]) & ~sh_size[w][31:16]) == 16'h0)) begin
                found = 1'b1;
                fw = w;
            end
        end
        if (!found) begin
            e.miss = 1'b1;
        end else begin
            p = sh_prot[2*fw +: 2];
            e.win   = IDX_W'(fw);
            e.tgt   = sh_base[fw][3:0];
            e.attr  = sh_base[fw][15:8];
            e.remap = sh_remap[fw];
            e.perm  = p;
            if (p == 2'b11 || (p == 2'b01 && !wr)) e.grant = 1'b1;
            else                                    e.deny  = 1'b1;
        end
        return e;
    endfunction

    task automatic cfg_wr(input logic [1:0] kind, input int idx, input logic [31:0] d);
        @(negedge clk);
        lk_valid  = 1'b0;
        cfg_we    = 1'b1;
        cfg_addr  = {kind, idx[IDX_W-1:0]};
        cfg_wdata = d;
        if (kind != 2'd3 && idx < NWIN) begin
            if (kind == 2'd0) sh_base[idx]  = d;
            if (kind == 2'd1) sh_size[idx]  = d;
            if (kind == 2'd2) sh_remap[idx] = d;
        end else if (kind == 2'd3) begin
            if (idx == 0) sh_en_n = d[NWIN-1:0];
            if (idx == 1) sh_prot = d[2*NWIN-1:0];
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // driver: presents a lookup and pushes its expected result
    task automatic lookup(input logic [31:0] a, input logic wr, input string tag);
        @(negedge clk);
        cfg_we   = 1'b0;
        lk_valid = 1'b1;
        lk_addr  = a;
        lk_write = wr;
        exp_q.push_back(model(a, wr));
        tag_q.push_back(tag);
    endtask

    task automatic check_idle(input string tag);
        @(negedge clk);
        lk_valid = 1'b0;
        @(posedge clk);
        #1;
        checks++;
        if (res_valid !== 1'b0) begin
            errors++;
            $display("FAIL %s idle res_valid actual %b expected 0", tag, res_valid);
        end
    endtask

    // monitor: pops and compares one expected item per produced result
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            if (exp_q.size() > 0) begin
                exp_t  e;
                exp_t  act;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                act = {res_grant, res_miss, res_deny, res_win, res_target,
                       res_attr, res_remap, res_perm};
                checks++;
                if (res_valid !== 1'b1 || act !== e) begin
                    errors++;
                    $display("FAIL %s valid=%b actual %h expected %h", t, res_valid, act, e);
                end
            end else if (res_valid !== 1'b0) begin
                checks++;
                errors++;
                $display("FAIL R8 unrequested result actual valid=%b expected 0", res_valid);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int w = 0; w < NWIN; w++) begin
            sh_base[w] = '0; sh_size[w] = '0; sh_remap[w] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: no result after reset, and reset config misses everything
        check_idle("R1");
        lookup(32'h1000_0000, 1'b0, "R1 reset miss");
        lookup(32'h0000_0000, 1'b1, "R1 reset miss zero");
        check_idle("R8");

        // window setup
        cfg_wr(2'd0, 0, 32'h1000_0E01);
        cfg_wr(2'd1, 0, 32'h000F_0000);
        cfg_wr(2'd2, 0, 32'hABCD_0000);
        cfg_wr(2'd0, 1, 32'h1000_3C07);
        cfg_wr(2'd1, 1, 32'h00FF_0000);
        cfg_wr(2'd2, 1, 32'h0000_0011);
        cfg_wr(2'd0, 2, 32'h2000_550A);
        cfg_wr(2'd1, 2, 32'h0000_0000);
        cfg_wr(2'd2, 2, 32'h0000_0002);
        cfg_wr(2'd0, 5, 32'h3000_A50F);
        cfg_wr(2'd1, 5, 32'h0003_0000);
        cfg_wr(2'd2, 5, 32'h0000_0055);
        cfg_wr(2'd3, 1, 32'h0000_0807);
        cfg_wr(2'd3, 0, 32'h0000_0018);

        // R3 / R4 / R5 / R6 / R7 / R10, back-to-back (R8)
        lookup(32'h1000_0004, 1'b0, "R4 overlap lowest wins");
        lookup(32'h100F_FFFC, 1'b1, "R3 window0 top word");
        lookup(32'h1080_0000, 1'b0, "R5 window1 fields");
        lookup(32'h1080_0000, 1'b1, "R6 read-only write deny");
        lookup(32'h0FFF_FFFF, 1'b0, "R3 below base miss");
        lookup(32'h3003_FFFC, 1'b0, "R6 perm 10 deny");
        lookup(32'h3004_0000, 1'b0, "R3 past window5 miss");
        lookup(32'h2000_FFFF, 1'b0, "R6 perm 00 deny");
        lookup(32'h2001_0000, 1'b0, "R3 64K window edge miss");
        lookup(32'h4000_0000, 1'b1, "R7 R10 miss zero fields");
        check_idle("R8");

        // R6: window5 permission at bits 11:10 set to full
        cfg_wr(2'd3, 1, 32'h0000_0C07);
        lookup(32'h3002_0000, 1'b1, "R6 window5 full write");
        lookup(32'h1000_0100, 1'b1, "R6 window0 full write");

        // R2
        cfg_wr(2'd3, 0, 32'h0000_003F);
        lookup(32'h1000_0004, 1'b0, "R2 all disabled miss");
        lookup(32'h3002_0000, 1'b0, "R2 all disabled miss w5");
        cfg_wr(2'd3, 0, 32'h0000_003D);
        lookup(32'h1000_0004, 1'b0, "R2 only window1 enabled");

        // R9: writes to absent indices and unused shared slots
        cfg_wr(2'd3, 0, 32'h0000_0000);
        cfg_wr(2'd0, 6, 32'h5000_0000);
        cfg_wr(2'd0, 7, 32'h5000_0000);
        cfg_wr(2'd2, 6, 32'hFFFF_FFFF);
        cfg_wr(2'd3, 2, 32'h0000_003F);
        cfg_wr(2'd3, 7, 32'h0000_0000);
        lookup(32'h5000_0000, 1'b0, "R9 absent window ignored");
        lookup(32'h1000_0004, 1'b0, "R9 window0 intact");
        lookup(32'h0000_1234, 1'b0, "R9 enable intact w3");
        check_idle("R8");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule